// File: doc/BRIEF.md
# Dual-Memory Bus Break Comparator

This block evaluates one break condition of a debug unit against the bus traffic of a DSP-style core. The core has a 32-bit main data bus and two separate 16-bit memory buses, X and Y. Each bus cycle is checked against a compare address with its mask, a compare data word with its mask, and qualifiers for direction, operand size and cycle type. A qualifying cycle produces a single-clock hit pulse one clock later.

By default the comparison watches the main bus. When the dual-memory mode bit is set, the comparison moves to one of the two narrow buses, chosen by a select bit. Each 32-bit configuration register then holds two 16-bit values. The upper half serves the X bus and the lower half serves the Y bus. A condition never covers both narrow buses at the same time. The configuration arrives on plain input ports, so the block contains no register file of its own.

Top module: `xyb_break_cmp`

## Requirements
- R1: While `rst_n` is low, and in the cycle after its release, `brk_hit` is 0.
- R2: In main-bus mode, an address compare bit is ignored where `cmp_addr_mask` holds 1. Every other bit of `m_addr` must equal `cmp_addr`.
- R3: The `cfg_rw` field sets the direction qualifier: 00 never matches, 01 matches reads (`write`=0), 10 matches writes, 11 matches both.
- R4: In main-bus mode, `cfg_size` of 00 accepts any operand size. Otherwise it must equal `m_size`. The size encoding is 01 byte, 10 word, 11 longword.
- R5: When `cfg_data_en` is 1, the bus data must also equal `cmp_data` on every bit where `cmp_data_mask` is 0. When `cfg_data_en` is 0, the data is ignored.
- R6: A main-bus cycle with `m_pref`=1 counts as a longword read without data. With `cfg_data_en`=1 it never matches. With `cfg_data_en`=0 it is judged on address, direction and size.
- R7: With `cfg_xy_en`=1 and `cfg_y_sel`=0, only the X bus is compared. The compare uses bits 31:16 of `cmp_addr`, `cmp_addr_mask`, `cmp_data` and `cmp_data_mask`. Y-bus and main-bus cycles are ignored.
- R8: With `cfg_xy_en`=1 and `cfg_y_sel`=1, only the Y bus is compared, against bits 15:0 of the same registers. X-bus and main-bus cycles are ignored, even in the same cycle.
- R9: In dual-memory mode, a match needs `cfg_size` of 00 or 10 (word). The values 01 and 11 never match.
- R10: No cycle matches unless `cfg_data_cyc` is 1, which selects data-access cycles.
- R11: `brk_hit` is registered. It is 1 exactly in the cycle after a qualifying bus cycle and 0 after a cycle with no qualifying access.
- R12: An address or data field whose mask is all ones matches any bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_xy_en | input | 1 | 1: compare on the X/Y memory buses instead of the main bus |
| cfg_y_sel | input | 1 | In dual-memory mode, 0 selects X and 1 selects Y |
| cfg_rw | input | 2 | Direction qualifier (00 none, 01 read, 10 write, 11 either) |
| cfg_size | input | 2 | Size qualifier (00 any, 01 byte, 10 word, 11 longword) |
| cfg_data_cyc | input | 1 | Data-access cycle qualifier; must be 1 for a match |
| cfg_data_en | input | 1 | Include the data compare |
| cmp_addr | input | 32 | Compare address (X in upper half, Y in lower half) |
| cmp_addr_mask | input | 32 | Address mask; 1 excludes a bit |
| cmp_data | input | 32 | Compare data (X in upper half, Y in lower half) |
| cmp_data_mask | input | 32 | Data mask; 1 excludes a bit |
| m_valid | input | 1 | Main-bus cycle present |
| m_write | input | 1 | Main-bus direction, 1 = write |
| m_size | input | 2 | Main-bus operand size |
| m_pref | input | 1 | Main-bus prefetch access |
| m_addr | input | 32 | Main-bus address |
| m_data | input | 32 | Main-bus data |
| x_valid | input | 1 | X-bus cycle present |
| x_write | input | 1 | X-bus direction, 1 = write |
| x_addr | input | 16 | X-bus address |
| x_data | input | 16 | X-bus data |
| y_valid | input | 1 | Y-bus cycle present |
| y_write | input | 1 | Y-bus direction, 1 = write |
| y_addr | input | 16 | Y-bus address |
| y_data | input | 16 | Y-bus data |
| brk_hit | output | 1 | One-clock break match pulse |

## Verification
The X and Y buses can both carry a cycle in the same clock, and only the selected one may decide the outcome. The bench drives both buses together. In one case the unselected bus carries a perfect match against its own register half while the selected bus misses, and the expected result is no hit. In the other case the roles are swapped and a hit is expected. A main-bus cycle that matches is also driven while dual-memory mode is active, and it must be ignored.

// File: rtl/xyb_pkg.sv
// Package xyb_pkg: shared qualifier encodings for the break comparator.
// Assumes 2-bit fields for the direction and size qualifiers.
package xyb_pkg;
    typedef enum logic [1:0] {
        RW_NONE = 2'b00,
        RW_RD   = 2'b01,
        RW_WR   = 2'b10,
        RW_ANY  = 2'b11
    } rw_qual_t;

    typedef enum logic [1:0] {
        SZ_ANY  = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LONG = 2'b11
    } size_qual_t;
endpackage

// File: rtl/xyb_mask_cmp.sv
// Module xyb_mask_cmp: masked equality of two vectors.
// A mask bit of 1 removes that bit from the comparison. Purely combinational.
module xyb_mask_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [W-1:0] mask,
    output logic         eq
);
    // compare only the unmasked bit positions
    always_comb begin
        eq = (((lhs ^ rhs) & ~mask) == '0);
    end

    // R12
    always_comb begin
        if (&mask) begin
            mask_full_chk: assert (eq);
        end
    end
endmodule

// File: rtl/xyb_src_sel.sv
// Module xyb_src_sel: picks the observed bus and the matching register half.
// Assumes each narrow bus is exactly half the main-bus width. In dual-memory
// mode the unused upper bits are padded with zero, and the mask is forced to
// ones there so that the padding never affects the result.
module xyb_src_sel #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int XY_W = 16
) (
    input  logic          xy_en,
    input  logic          y_sel,
    input  logic          m_valid,
    input  logic          m_write,
    input  logic [AW-1:0] m_addr,
    input  logic [DW-1:0] m_data,
    input  logic          x_valid,
    input  logic          x_write,
    input  logic [XY_W-1:0] x_addr,
    input  logic [XY_W-1:0] x_data,
    input  logic          y_valid,
    input  logic          y_write,
    input  logic [XY_W-1:0] y_addr,
    input  logic [XY_W-1:0] y_data,
    input  logic [AW-1:0] ref_addr_in,
    input  logic [AW-1:0] ref_amask_in,
    input  logic [DW-1:0] ref_data_in,
    input  logic [DW-1:0] ref_dmask_in,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    output logic [AW-1:0] ref_addr,
    output logic [AW-1:0] ref_amask,
    output logic [DW-1:0] ref_data,
    output logic [DW-1:0] ref_dmask
);
    localparam int APAD = AW - XY_W;
    localparam int DPAD = DW - XY_W;

    logic [XY_W-1:0] n_addr, n_data, r_addr, r_amask, r_data, r_dmask;
    logic            n_valid, n_write;

    // choose the narrow bus and the register half that belongs to it
    always_comb begin
        if (y_sel) begin
            n_valid = y_valid;
            n_write = y_write;
            n_addr  = y_addr;
            n_data  = y_data;
            r_addr  = ref_addr_in[XY_W-1:0];
            r_amask = ref_amask_in[XY_W-1:0];
            r_data  = ref_data_in[XY_W-1:0];
            r_dmask = ref_dmask_in[XY_W-1:0];
        end else begin
            n_valid = x_valid;
            n_write = x_write;
            n_addr  = x_addr;
            n_data  = x_data;
            r_addr  = ref_addr_in[AW-1 -: XY_W];
            r_amask = ref_amask_in[AW-1 -: XY_W];
            r_data  = ref_data_in[DW-1 -: XY_W];
            r_dmask = ref_dmask_in[DW-1 -: XY_W];
        end
    end

    // route either the main bus or the chosen narrow bus to the comparators
    always_comb begin
        if (xy_en) begin
            bus_valid = n_valid;
            bus_write = n_write;
            bus_addr  = {{APAD{1'b0}}, n_addr};
            bus_data  = {{DPAD{1'b0}}, n_data};
            ref_addr  = {{APAD{1'b0}}, r_addr};
            ref_amask = {{APAD{1'b1}}, r_amask};
            ref_data  = {{DPAD{1'b0}}, r_data};
            ref_dmask = {{DPAD{1'b1}}, r_dmask};
        end else begin
            bus_valid = m_valid;
            bus_write = m_write;
            bus_addr  = m_addr;
            bus_data  = m_data;
            ref_addr  = ref_addr_in;
            ref_amask = ref_amask_in;
            ref_data  = ref_data_in;
            ref_dmask = ref_dmask_in;
        end
    end
endmodule

// File: rtl/xyb_qual.sv
// Module xyb_qual: cycle qualification (cycle type, direction, size, prefetch).
// Assumes a prefetch is seen only on the main bus and behaves as a longword
// read that carries no data.
module xyb_qual
    import xyb_pkg::*;
(
    input  logic       xy_en,
    input  logic       data_cyc,
    input  logic       data_en,
    input  logic [1:0] rw_cfg,
    input  logic [1:0] size_cfg,
    input  logic       bus_valid,
    input  logic       bus_write,
    input  logic [1:0] m_size,
    input  logic       m_pref,
    output logic       qual_ok
);
    rw_qual_t   rw_q;
    size_qual_t sz_q;
    logic       eff_write, rw_ok, size_ok, pref_block;
    logic [1:0] eff_size;

    // a prefetch on the main bus overrides the direction and size
    always_comb begin
        rw_q      = rw_qual_t'(rw_cfg);
        sz_q      = size_qual_t'(size_cfg);
        eff_write = (!xy_en && m_pref) ? 1'b0 : bus_write;
        eff_size  = m_pref ? SZ_LONG : m_size;
    end

    // check the direction qualifier
    always_comb begin
        unique case (rw_q)
            RW_NONE: rw_ok = 1'b0;
            RW_RD:   rw_ok = !eff_write;
            RW_WR:   rw_ok = eff_write;
            default: rw_ok = 1'b1;
        endcase
    end

    // check the size qualifier; the narrow buses accept only word or any
    always_comb begin
        if (xy_en) size_ok = (sz_q == SZ_ANY) || (sz_q == SZ_WORD);
        else       size_ok = (sz_q == SZ_ANY) || (size_cfg == eff_size);
        pref_block = !xy_en && m_pref && data_en;
        qual_ok    = bus_valid && data_cyc && rw_ok && size_ok && !pref_block;
    end
endmodule

// File: rtl/xyb_break_cmp.sv
// Module xyb_break_cmp: break-condition comparator for the main bus and the
// X/Y memory buses. Assumes the configuration ports are stable register
// outputs. Produces a registered hit pulse one clock after a qualifying cycle.
module xyb_break_cmp #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int XY_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_xy_en,
    input  logic            cfg_y_sel,
    input  logic [1:0]      cfg_rw,
    input  logic [1:0]      cfg_size,
    input  logic            cfg_data_cyc,
    input  logic            cfg_data_en,
    input  logic [AW-1:0]   cmp_addr,
    input  logic [AW-1:0]   cmp_addr_mask,
    input  logic [DW-1:0]   cmp_data,
    input  logic [DW-1:0]   cmp_data_mask,
    input  logic            m_valid,
    input  logic            m_write,
    input  logic [1:0]      m_size,
    input  logic            m_pref,
    input  logic [AW-1:0]   m_addr,
    input  logic [DW-1:0]   m_data,
    input  logic            x_valid,
    input  logic            x_write,
    input  logic [XY_W-1:0] x_addr,
    input  logic [XY_W-1:0] x_data,
    input  logic            y_valid,
    input  logic            y_write,
    input  logic [XY_W-1:0] y_addr,
    input  logic [XY_W-1:0] y_data,
    output logic            brk_hit
);
    logic          bus_valid, bus_write, qual_ok, addr_eq, data_eq, hit_c;
    logic [AW-1:0] bus_addr, ref_addr, ref_amask;
    logic [DW-1:0] bus_data, ref_data, ref_dmask;

    xyb_src_sel #(.AW(AW), .DW(DW), .XY_W(XY_W)) u_sel (
        .xy_en(cfg_xy_en), .y_sel(cfg_y_sel),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_data(m_data),
        .x_valid(x_valid), .x_write(x_write), .x_addr(x_addr), .x_data(x_data),
        .y_valid(y_valid), .y_write(y_write), .y_addr(y_addr), .y_data(y_data),
        .ref_addr_in(cmp_addr), .ref_amask_in(cmp_addr_mask),
        .ref_data_in(cmp_data), .ref_dmask_in(cmp_data_mask),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .ref_addr(ref_addr), .ref_amask(ref_amask),
        .ref_data(ref_data), .ref_dmask(ref_dmask)
    );

    xyb_qual u_qual (
        .xy_en(cfg_xy_en), .data_cyc(cfg_data_cyc), .data_en(cfg_data_en),
        .rw_cfg(cfg_rw), .size_cfg(cfg_size),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .m_size(m_size), .m_pref(m_pref), .qual_ok(qual_ok)
    );

    xyb_mask_cmp #(.W(AW)) u_acmp (
        .lhs(bus_addr), .rhs(ref_addr), .mask(ref_amask), .eq(addr_eq)
    );

    xyb_mask_cmp #(.W(DW)) u_dcmp (
        .lhs(bus_data), .rhs(ref_data), .mask(ref_dmask), .eq(data_eq)
    );

    // combine the qualifier with the address and optional data compare
    always_comb begin
        hit_c = qual_ok && addr_eq && (!cfg_data_en || data_eq);
    end

    // register the hit so it appears for one clock after the bus cycle
    always_ff @(posedge clk) begin
        if (!rst_n) brk_hit <= 1'b0;
        else        brk_hit <= hit_c;
    end

    // R3
    rw_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rw == 2'b00) |=> !brk_hit);

    // R6
    pref_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_xy_en && m_pref && cfg_data_en) |=> !brk_hit);

    // R9
    xy_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_xy_en && cfg_size[0]) |=> !brk_hit);

    // R10
    cyc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_data_cyc |=> !brk_hit);

    // R11
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_valid || x_valid || y_valid) |=> !brk_hit);
endmodule

// File: tb/xyb_break_cmp_bench.sv
`timescale 1ns/1ps
module xyb_break_cmp_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_xy_en, cfg_y_sel, cfg_data_cyc, cfg_data_en;
    logic [1:0]  cfg_rw, cfg_size;
    logic [31:0] cmp_addr, cmp_addr_mask, cmp_data, cmp_data_mask;
    logic        m_valid, m_write, m_pref;
    logic [1:0]  m_size;
    logic [31:0] m_addr, m_data;
    logic        x_valid, x_write, y_valid, y_write;
    logic [15:0] x_addr, x_data, y_addr, y_data;
    logic        brk_hit;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    xyb_break_cmp u_xyb_break_cmp (.*);

    // wait one cycle, then compare the registered hit against the expectation
    task automatic expect_hit(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (brk_hit !== exp) begin
            failures++;
            $display("FAIL %s: brk_hit=%b expected=%b", tag, brk_hit, exp);
        end
    endtask

    task automatic defaults();
        cfg_xy_en = 0; cfg_y_sel = 0; cfg_rw = 2'b11; cfg_size = 2'b00;
        cfg_data_cyc = 1; cfg_data_en = 0;
        cmp_addr = 32'h1234_5678; cmp_addr_mask = 32'h0;
        cmp_data = 32'hABCD_0F0F; cmp_data_mask = 32'h0;
        m_valid = 0; m_write = 0; m_size = 2'b11; m_pref = 0;
        m_addr = 32'h1234_5678; m_data = 32'hABCD_0F0F;
        x_valid = 0; x_write = 0; x_addr = 16'h1234; x_data = 16'hABCD;
        y_valid = 0; y_write = 0; y_addr = 16'h5678; y_data = 16'h0F0F;
    endtask

    task automatic t_reset();
        defaults(); rst_n = 0; m_valid = 1;
        expect_hit(0, "R1 in reset");
        expect_hit(0, "R1 in reset");
        rst_n = 1; m_valid = 0;
        expect_hit(0, "R1 after release");
    endtask

    task automatic t_addr();
        defaults(); m_valid = 1;
        expect_hit(1, "R2 exact address");
        m_addr = 32'h1234_5679;
        expect_hit(0, "R2 address mismatch");
        cmp_addr_mask = 32'h0000_000F;
        expect_hit(1, "R2 masked low bits");
        m_addr = 32'h1234_5698;
        expect_hit(0, "R2 unmasked bit differs");
    endtask

    task automatic t_rw();
        for (int rw = 0; rw < 4; rw++) begin
            for (int w = 0; w < 2; w++) begin
                defaults(); m_valid = 1; cfg_rw = rw[1:0]; m_write = w[0];
                expect_hit((rw == 3) || (rw == 1 && w == 0) || (rw == 2 && w == 1),
                           "R3 direction qualifier");
            end
        end
    endtask

    task automatic t_size();
        defaults(); m_valid = 1; cfg_size = 2'b01; m_size = 2'b10;
        expect_hit(0, "R4 byte vs word");
        m_size = 2'b01;
        expect_hit(1, "R4 byte vs byte");
        cfg_size = 2'b00; m_size = 2'b10;
        expect_hit(1, "R4 any size");
    endtask

    task automatic t_data();
        defaults(); m_valid = 1; cfg_data_en = 1;
        expect_hit(1, "R5 data equal");
        m_data = 32'hABCD_0F0E;
        expect_hit(0, "R5 data differs");
        cmp_data_mask = 32'h0000_0001;
        expect_hit(1, "R5 data masked");
        cfg_data_en = 0; cmp_data_mask = 0; m_data = 32'h0;
        expect_hit(1, "R5 data ignored when disabled");
    endtask

    task automatic t_pref();
        defaults(); m_valid = 1; m_pref = 1; cfg_data_en = 1;
        expect_hit(0, "R6 prefetch with data compare");
        cfg_data_en = 0; cfg_rw = 2'b01; cfg_size = 2'b11; m_size = 2'b01; m_write = 1;
        expect_hit(1, "R6 prefetch as longword read");
        cfg_rw = 2'b10;
        expect_hit(0, "R6 prefetch is not a write");
    endtask

    task automatic t_xbus();
        defaults(); cfg_xy_en = 1; cfg_y_sel = 0; cfg_data_en = 1; cfg_size = 2'b10;
        x_valid = 1;
        expect_hit(1, "R7 X upper halves");
        x_addr = 16'h5678;
        expect_hit(0, "R7 X against lower half");
        x_valid = 0; x_addr = 16'h1234; y_valid = 1; m_valid = 1;
        expect_hit(0, "R7 Y and main ignored");
        x_valid = 1; x_data = 16'hABCC;
        expect_hit(0, "R7 X data mismatch");
    endtask

    task automatic t_ybus();
        defaults(); cfg_xy_en = 1; cfg_y_sel = 1; cfg_data_en = 1;
        y_valid = 1;
        expect_hit(1, "R8 Y lower halves");
        y_valid = 1; y_addr = 16'h5679; x_valid = 1;
        expect_hit(0, "R8 X match ignored while Y misses");
        cfg_y_sel = 0; x_addr = 16'h1235; y_addr = 16'h5678;
        expect_hit(0, "R7 Y match ignored while X misses");
        cfg_y_sel = 1;
        expect_hit(1, "R8 both buses active, Y matches");
    endtask

    task automatic t_xysize();
        for (int s = 0; s < 4; s++) begin
            defaults(); cfg_xy_en = 1; x_valid = 1; cfg_size = s[1:0];
            expect_hit(s == 0 || s == 2, "R9 narrow bus size");
        end
    endtask

    task automatic t_cyc();
        defaults(); m_valid = 1; cfg_data_cyc = 0;
        expect_hit(0, "R10 main without data cycle");
        cfg_xy_en = 1; x_valid = 1;
        expect_hit(0, "R10 X without data cycle");
    endtask

    task automatic t_pulse();
        defaults(); m_valid = 1;
        expect_hit(1, "R11 pulse high");
        m_valid = 0;
        expect_hit(0, "R11 pulse ends");
        m_valid = 1;
        expect_hit(1, "R11 back to back 1");
        expect_hit(1, "R11 back to back 2");
        m_valid = 0;
        expect_hit(0, "R11 idle");
    endtask

    task automatic t_fullmask();
        defaults(); cfg_data_en = 1; cmp_addr_mask = '1; cmp_data_mask = '1;
        m_valid = 1; m_addr = 32'hDEAD_BEEF; m_data = 32'h0BAD_F00D;
        expect_hit(1, "R12 main full masks");
        cfg_xy_en = 1; cfg_y_sel = 1; m_valid = 0; y_valid = 1;
        y_addr = 16'hFFFF; y_data = 16'h0000;
        expect_hit(1, "R12 Y full masks");
    endtask

    initial begin
        defaults(); rst_n = 0;
        @(negedge clk);
        t_reset(); t_addr(); t_rw(); t_size(); t_data(); t_pref();
        t_xbus(); t_ybus(); t_xysize(); t_cyc(); t_pulse(); t_fullmask();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule